// File: doc/BRIEF.md
# Single-Dword Host Memory Read Requester

This block fetches one 32-bit word from host memory across a PCIe link. Software first loads a 64-bit bus address into an address register and then pulses a separate launch strobe. The block snapshots the address, picks the short (three-dword) or long (four-dword) memory-read header depending on whether the upper 32 address bits are zero, and streams that header one dword per cycle to the transaction-layer core on a ready/valid transmit port with start and end markers.

Once the header has left, the block waits on a receive stream for a completion whose tag equals the one it sent. A successful completion with data latches its first payload dword and raises a done flag. A completion without data, or one carrying a non-success status, raises a completion error and keeps the three-bit status. If no matching completion arrives within a programmable number of cycles, a timeout flag is raised instead. Each accepted launch uses the next tag value.

Top module: `dma_rd_requester`

## Requirements
- R1: Header dword 0 holds the format in bits 31:29 (000 when address bits 63:32 are all zero, 001 otherwise), a zero type in bits 28:24, zeros in bits 23:10 (traffic class, attributes, digest, poison, translation and hint bits) and a length of 1 in bits 9:0.
- R2: A short-form request is three beats long and its third beat is the address with bits 1:0 forced to zero. A long-form request is four beats long, with address bits 63:32 on the third beat and the lower address dword, bits 1:0 zero, on the fourth.
- R3: Header dword 1 carries the requester ID input in bits 31:16, the tag in bits 15:8, a last-dword byte enable of 0000 in bits 7:4 and a first-dword byte enable of 1111 in bits 3:0.
- R4: The start marker is high only on the first header beat and the end marker only on the last. While valid is high and ready is low, the beat and its markers hold steady.
- R5: The first request after reset uses tag 0. Each accepted launch uses the previous tag plus one, wrapping from 255 to 0.
- R6: A completion with format 010 (bits 31:29 of its dword 0), type 01010 (bits 28:24), status 000 (bits 15:13 of dword 1) and a matching tag (bits 15:8 of dword 2) sets done and puts its dword 3 on the read-data output. This takes effect in the cycle after its end beat, when busy also drops.
- R7: A matching completion with format 000 and type 01010, or a data completion with a non-zero status, sets the completion error flag and leaves its status field on the status output. Done stays low.
- R8: A completion whose tag differs from the outstanding one, or one that arrives while no request is waiting, changes no flag and no read data.
- R9: With a non-zero timeout value N, the timeout flag rises and busy drops exactly N cycles after the last header beat is accepted, provided no matching completion has arrived. A value of 0 disables the timeout.
- R10: A launch strobe while busy is ignored: no new header appears and the in-flight request keeps its address and tag. An accepted launch clears done, the completion error flag and the timeout flag.
- R11: After reset, busy, transmit valid, done and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgReqId | input | 16 | Requester ID placed in the header |
| timeoutCycles | input | 16 | Completion wait limit in cycles, 0 disables; sampled at launch |
| regAddrWe | input | 1 | Write strobe for the address register |
| regAddrData | input | 64 | Bus address to load |
| regStartWe | input | 1 | Launch strobe |
| txData | output | 32 | Header beat |
| txValid | output | 1 | Header beat valid |
| txReady | input | 1 | Sink accepts the beat |
| txSop | output | 1 | First header beat |
| txEop | output | 1 | Last header beat |
| rxData | input | 32 | Completion beat |
| rxValid | input | 1 | Completion beat valid |
| rxSop | input | 1 | First completion beat |
| rxEop | input | 1 | Last completion beat |
| busy | output | 1 | A request is being sent or awaited |
| done | output | 1 | Read finished with data |
| errCpl | output | 1 | Completion reported failure |
| errStatus | output | 3 | Status of the failed completion |
| errTimeout | output | 1 | No completion arrived in time |
| rdData | output | 32 | Returned data dword |

## Verification
The assertions assume that completion beats arrive as whole packets: the start marker appears on the first beat, and the end marker appears on beat three for a completion without data or on beat four for one with data. They also assume the address register is not written in the same cycle as a launch. The bench drives completions only through a task that builds packets of exactly those lengths. It writes the address one cycle before each launch, and it stalls the transmit port at random so the hold rule is exercised without breaking those assumptions.

// File: rtl/dmard_pkg.sv
package dmard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT
  } stateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic       latchReq;
    logic [1:0] beatSel;
    logic       captureOk;
    logic       captureFail;
    logic       flagTimeout;
  } strobeT;

  localparam logic [2:0] FMT_SHORT_NODATA = 3'b000;
  localparam logic [2:0] FMT_LONG_NODATA  = 3'b001;
  localparam logic [2:0] FMT_SHORT_DATA   = 3'b010;
  localparam logic [4:0] TYPE_MEMRD       = 5'b00000;
  localparam logic [4:0] TYPE_CPL         = 5'b01010;
  localparam logic [2:0] CPL_SUCCESS      = 3'b000;
  localparam logic [9:0] LEN_ONE_DW       = 10'd1;
  localparam logic [3:0] BE_LAST_NONE     = 4'b0000;
  localparam logic [3:0] BE_FIRST_ALL     = 4'b1111;

endpackage

// File: rtl/dmard_ctrl.sv
module dmard_ctrl
  import dmard_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startWe,
  input  logic             is4dw,
  input  logic             txReady,
  input  logic             cplMatch,
  input  logic             cplGood,
  input  logic [TMO_W-1:0] timeoutCycles,
  output strobeT           strb,
  output logic             txValid,
  output logic             txSop,
  output logic             txEop,
  output logic             busy
);

  localparam logic [1:0] LAST_SHORT = 2'd2;
  localparam logic [1:0] LAST_LONG  = 2'd3;

  stateT            state;
  logic [1:0]       beatIdx;
  logic [TMO_W-1:0] waitCnt;
  logic [TMO_W-1:0] tmoLimit;
  logic             lastBeat;
  logic             waitEnd;

  assign lastBeat = (beatIdx == (is4dw ? LAST_LONG : LAST_SHORT));
  assign txValid  = (state == ST_SEND);
  assign txSop    = txValid && (beatIdx == 2'd0);
  assign txEop    = txValid && lastBeat;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb          = '0;
    strb.beatSel  = beatIdx;
    strb.latchReq = (state == ST_IDLE) && startWe;
    if (state == ST_WAIT) begin
      if (cplMatch) begin
        strb.captureOk   = cplGood;
        strb.captureFail = !cplGood;
      end else if ((tmoLimit != '0) && (waitCnt == tmoLimit - 1'b1)) begin
        strb.flagTimeout = 1'b1;
      end
    end
  end

  assign waitEnd = strb.captureOk || strb.captureFail || strb.flagTimeout;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      beatIdx  <= '0;
      waitCnt  <= '0;
      tmoLimit <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startWe) begin
            state    <= ST_SEND;
            beatIdx  <= '0;
            tmoLimit <= timeoutCycles;
          end
        end
        ST_SEND: begin
          if (txReady) begin
            if (lastBeat) begin
              state   <= ST_WAIT;
              waitCnt <= '0;
            end else begin
              beatIdx <= beatIdx + 2'd1;
            end
          end
        end
        ST_WAIT: begin
          if (waitEnd) state <= ST_IDLE;
          else         waitCnt <= waitCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an idle launch produces the first header beat next cycle
  assert_launch_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startWe) |=> (txValid && txSop));

  // R4: markers never both raised on the first beat of a long header
  assert_eop_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txSop && is4dw) |-> !txEop);

endmodule

// File: rtl/dmard_dp.sv
module dmard_dp
  import dmard_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int TAG_W  = 8,
  parameter int RID_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [RID_W-1:0]  cfgReqId,
  input  logic              regAddrWe,
  input  logic [ADDR_W-1:0] regAddrData,
  input  logic [31:0]       rxData,
  input  logic              rxValid,
  input  logic              rxSop,
  input  logic              rxEop,
  output logic              is4dw,
  output logic [31:0]       txData,
  output logic              cplMatch,
  output logic              cplGood,
  output logic [31:0]       rdData,
  output logic              done,
  output logic              errCpl,
  output logic [2:0]        errStatus,
  output logic              errTimeout
);

  localparam int LO_W = 32;
  localparam int HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] reqAddr;
  logic [TAG_W-1:0]  nextTag;
  logic [TAG_W-1:0]  reqTag;
  logic [LO_W-1:0]   addrLoDw;
  logic [LO_W-1:0]   addrHiDw;

  // completion parser state
  logic [1:0]       rxIdx;
  logic [1:0]       rxPos;
  logic [2:0]       fmtR;
  logic [4:0]       typR;
  logic [2:0]       stsR;
  logic [TAG_W-1:0] tagR;
  logic [TAG_W-1:0] tagNow;
  logic             endNoData;
  logic             endData;

  assign is4dw    = |reqAddr[ADDR_W-1:LO_W];
  assign addrLoDw = {reqAddr[LO_W-1:2], 2'b00};

  generate
    if (HI_W >= LO_W) begin : g_hiFull
      assign addrHiDw = reqAddr[LO_W +: LO_W];
    end else begin : g_hiPad
      assign addrHiDw = {{(LO_W-HI_W){1'b0}}, reqAddr[ADDR_W-1:LO_W]};
    end
  endgenerate

  // header beat select
  always_comb begin
    unique case (strb.beatSel)
      2'd0: txData = {(is4dw ? FMT_LONG_NODATA : FMT_SHORT_NODATA), TYPE_MEMRD,
                      14'd0, LEN_ONE_DW};
      2'd1: txData = {cfgReqId, reqTag, BE_LAST_NONE, BE_FIRST_ALL};
      2'd2: txData = is4dw ? addrHiDw : addrLoDw;
      default: txData = addrLoDw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      reqAddr <= '0;
      nextTag <= '0;
      reqTag  <= '0;
    end else begin
      if (regAddrWe) addrReg <= regAddrData;
      if (strb.latchReq) begin
        reqAddr <= addrReg;
        reqTag  <= nextTag;
        nextTag <= nextTag + 1'b1;
      end
    end
  end

  // completion beat position and field capture
  assign rxPos = rxSop ? 2'd0 : rxIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIdx <= '0;
      fmtR  <= '0;
      typR  <= '0;
      stsR  <= '0;
      tagR  <= '0;
    end else if (rxValid) begin
      if (rxSop) begin
        rxIdx <= 2'd1;
        fmtR  <= rxData[31:29];
        typR  <= rxData[28:24];
      end else begin
        if (rxIdx != 2'd3) rxIdx <= rxIdx + 2'd1;
        if (rxPos == 2'd1) stsR <= rxData[15:13];
        if (rxPos == 2'd2) tagR <= rxData[15:8];
      end
    end
  end

  assign tagNow    = (rxPos == 2'd2) ? rxData[15:8] : tagR;
  assign endNoData = (rxPos == 2'd2) && (fmtR == FMT_SHORT_NODATA);
  assign endData   = (rxPos == 2'd3) && (fmtR == FMT_SHORT_DATA);
  assign cplMatch  = rxValid && rxEop && !rxSop && (typR == TYPE_CPL) &&
                     (tagNow == reqTag) && (endNoData || endData);
  assign cplGood   = endData && (stsR == CPL_SUCCESS);

  // result flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData     <= '0;
      done       <= 1'b0;
      errCpl     <= 1'b0;
      errStatus  <= '0;
      errTimeout <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        done       <= 1'b0;
        errCpl     <= 1'b0;
        errStatus  <= '0;
        errTimeout <= 1'b0;
      end
      if (strb.captureOk) begin
        done   <= 1'b1;
        rdData <= rxData;
      end
      if (strb.captureFail) begin
        errCpl    <= 1'b1;
        errStatus <= stsR;
      end
      if (strb.flagTimeout) errTimeout <= 1'b1;
    end
  end

  // R5: each accepted launch steps the tag counter by one
  assert_tag_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchReq |=> (nextTag == $past(nextTag) + 1'b1));

  // R7: a failure capture leaves the parsed status on the output
  assert_fail_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureFail |=> (errCpl && !done && errStatus == $past(stsR)));

endmodule

// File: rtl/dma_rd_requester.sv
module dma_rd_requester
  import dmard_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int TAG_W  = 8,
  parameter int TMO_W  = 16,
  parameter int RID_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RID_W-1:0]  cfgReqId,
  input  logic [TMO_W-1:0]  timeoutCycles,
  input  logic              regAddrWe,
  input  logic [ADDR_W-1:0] regAddrData,
  input  logic              regStartWe,
  output logic [31:0]       txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txSop,
  output logic              txEop,
  input  logic [31:0]       rxData,
  input  logic              rxValid,
  input  logic              rxSop,
  input  logic              rxEop,
  output logic              busy,
  output logic              done,
  output logic              errCpl,
  output logic [2:0]        errStatus,
  output logic              errTimeout,
  output logic [31:0]       rdData
);

  strobeT strb;
  logic   is4dw;
  logic   cplMatch;
  logic   cplGood;

  dmard_ctrl #(.TMO_W(TMO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startWe(regStartWe), .is4dw(is4dw),
    .txReady(txReady), .cplMatch(cplMatch), .cplGood(cplGood),
    .timeoutCycles(timeoutCycles), .strb(strb), .txValid(txValid),
    .txSop(txSop), .txEop(txEop), .busy(busy)
  );

  dmard_dp #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .RID_W(RID_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgReqId(cfgReqId),
    .regAddrWe(regAddrWe), .regAddrData(regAddrData), .rxData(rxData),
    .rxValid(rxValid), .rxSop(rxSop), .rxEop(rxEop), .is4dw(is4dw),
    .txData(txData), .cplMatch(cplMatch), .cplGood(cplGood),
    .rdData(rdData), .done(done), .errCpl(errCpl), .errStatus(errStatus),
    .errTimeout(errTimeout)
  );

  // R4: a stalled beat holds its data and markers
  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txSop) && $stable(txEop)));

  // R6: at most one outcome flag is ever raised
  assert_outcome_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, errCpl, errTimeout}));

  // R9: a timeout ends the request
  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> !busy);

  // R11: nothing is sent while idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txValid);

endmodule

// File: tb/sim_dma_rd_requester.sv
module sim_dma_rd_requester;

  localparam logic [15:0] REQ_ID = 16'h0A30;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cfgReqId;
  logic [15:0] timeoutCycles;
  logic        regAddrWe;
  logic [63:0] regAddrData;
  logic        regStartWe;
  logic [31:0] txData;
  logic        txValid, txReady, txSop, txEop;
  logic [31:0] rxData;
  logic        rxValid, rxSop, rxEop;
  logic        busy, done, errCpl, errTimeout;
  logic [2:0]  errStatus;
  logic [31:0] rdData;

  always #4 clk = ~clk;

  dma_rd_requester u0 (
    .clk(clk), .rstN(rstN), .cfgReqId(cfgReqId), .timeoutCycles(timeoutCycles),
    .regAddrWe(regAddrWe), .regAddrData(regAddrData), .regStartWe(regStartWe),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txSop(txSop),
    .txEop(txEop), .rxData(rxData), .rxValid(rxValid), .rxSop(rxSop),
    .rxEop(rxEop), .busy(busy), .done(done), .errCpl(errCpl),
    .errStatus(errStatus), .errTimeout(errTimeout), .rdData(rdData)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [31:0] cap [4];
  int          capN;
  logic        markOk;
  logic [7:0]  expTag;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expHdr(input logic [63:0] a, input logic [7:0] tg, input int idx);
    logic is4;
    is4 = (a[63:32] != 32'd0);
    case (idx)
      0: return {(is4 ? 3'b001 : 3'b000), 5'b00000, 14'd0, 10'd1};
      1: return {REQ_ID, tg, 4'b0000, 4'b1111};
      2: return is4 ? a[63:32] : {a[31:2], 2'b00};
      default: return {a[31:2], 2'b00};
    endcase
  endfunction

  // write address, launch, collect header under random back-pressure
  task automatic issue(input logic [63:0] a);
    bit fin;
    @(negedge clk); regAddrWe = 1'b1; regAddrData = a;
    @(negedge clk); regAddrWe = 1'b0; regStartWe = 1'b1;
    @(negedge clk); regStartWe = 1'b0;
    capN = 0; markOk = 1'b1; fin = 0;
    for (int k = 0; k < 60 && !fin; k++) begin
      txReady = ($urandom % 4) != 0;
      #1;
      if (txValid && txReady) begin
        if (capN < 4) cap[capN] = txData;
        if (txSop != (capN == 0)) markOk = 1'b0;
        if (txEop) fin = 1;
        capN++;
      end
      if (!fin) @(negedge clk);
    end
    txReady = 1'b1;
  endtask

  task automatic checkHdr(input logic [63:0] a, input logic [7:0] tg);
    int n;
    n = (a[63:32] != 0) ? 4 : 3;
    chk("R2 beat count", 64'(capN), 64'(n));
    chk("R1 header dw0", {32'd0, cap[0]}, {32'd0, expHdr(a, tg, 0)});
    chk("R3 header dw1", {32'd0, cap[1]}, {32'd0, expHdr(a, tg, 1)});
    chk("R2 header dw2", {32'd0, cap[2]}, {32'd0, expHdr(a, tg, 2)});
    if (n == 4) chk("R2 header dw3", {32'd0, cap[3]}, {32'd0, expHdr(a, tg, 3)});
    chk("R4 sop/eop placement", {63'd0, markOk}, 64'd1);
  endtask

  task automatic sendCpl(input logic [2:0] fmt, input logic [2:0] sts,
                         input logic [7:0] tg, input logic [31:0] data);
    int n;
    logic [31:0] beat;
    n = (fmt == 3'b010) ? 4 : 3;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (i)
        0: beat = {fmt, 5'b01010, 14'd0, (fmt == 3'b010) ? 10'd1 : 10'd0};
        1: beat = {16'h0100, sts, 1'b0, 12'd4};
        2: beat = {REQ_ID, tg, 1'b0, 7'd0};
        default: beat = data;
      endcase
      rxValid = 1'b1; rxSop = (i == 0); rxEop = (i == n - 1); rxData = beat;
    end
    @(negedge clk);
    rxValid = 1'b0; rxSop = 1'b0; rxEop = 1'b0; rxData = '0;
  endtask

  function automatic logic [63:0] randAddr();
    logic [63:0] a;
    a = {$urandom, $urandom};
    if ($urandom % 2) a[63:32] = 32'd0;
    else if (a[63:32] == 0) a[40] = 1'b1;
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    logic [31:0] d;
    logic [2:0]  s;
    int          r;
    void'($urandom(32'd20240611));
    rstN = 1'b0; cfgReqId = REQ_ID; timeoutCycles = 16'd400;
    regAddrWe = 0; regAddrData = '0; regStartWe = 0; txReady = 1'b1;
    rxData = '0; rxValid = 0; rxSop = 0; rxEop = 0;
    expTag = 8'd0;
    repeat (3) @(negedge clk);
    chk("R11 busy after reset", {63'd0, busy}, 64'd0);
    chk("R11 txValid after reset", {63'd0, txValid}, 64'd0);
    chk("R11 flags after reset", {61'd0, done, errCpl, errTimeout}, 64'd0);
    rstN = 1'b1;

    // long form, success
    a = 64'h0000_0001_2345_6788;
    issue(a); checkHdr(a, expTag);
    sendCpl(3'b010, 3'b000, expTag, 32'hCAFE_0001);
    chk("R6 done", {62'd0, done, busy}, 64'd2);
    chk("R6 read data", {32'd0, rdData}, 64'h0000_0000_CAFE_0001);
    expTag++;

    // 64-bit value with zero upper half uses short form; UR no-data completion
    a = 64'h0000_0000_DEAD_BEEF;
    issue(a); checkHdr(a, expTag);
    sendCpl(3'b000, 3'b001, expTag, 32'd0);
    chk("R7 error flags", {61'd0, done, errCpl, errTimeout}, 64'd2);
    chk("R7 status", {61'd0, errStatus}, 64'd1);
    expTag++;

    // flags cleared on accepted launch; mismatched tag ignored
    a = 64'h0000_0000_0000_1000;
    issue(a);
    chk("R10 flags cleared on launch", {61'd0, done, errCpl, errTimeout}, 64'd0);
    checkHdr(a, expTag);
    sendCpl(3'b010, 3'b000, expTag ^ 8'h5A, 32'h1111_1111);
    chk("R8 wrong tag keeps waiting", {62'd0, busy, done}, 64'd2);
    sendCpl(3'b010, 3'b000, expTag, 32'h2222_2222);
    chk("R6 after wrong tag", {32'd0, rdData}, 64'h0000_0000_2222_2222);
    expTag++;

    // completion while idle ignored
    sendCpl(3'b010, 3'b000, expTag - 8'd1, 32'h3333_3333);
    chk("R8 idle completion ignored", {31'd0, rdData, done}, {31'd0, 32'h2222_2222, 1'b1});

    // timeout window
    timeoutCycles = 16'd20;
    a = 64'h0000_0000_0000_2000;
    issue(a); checkHdr(a, expTag);
    repeat (20) @(negedge clk);
    chk("R9 no timeout one cycle early", {62'd0, errTimeout, busy}, 64'd1);
    @(negedge clk);
    chk("R9 timeout at limit", {62'd0, errTimeout, busy}, 64'd2);
    expTag++;
    timeoutCycles = 16'd0;

    // timeout disabled, launch while busy ignored
    a = 64'h0000_0042_0000_3004;
    issue(a); checkHdr(a, expTag);
    repeat (30) @(negedge clk);
    chk("R9 disabled timeout keeps waiting", {62'd0, errTimeout, busy}, 64'd1);
    regAddrWe = 1'b1; regAddrData = 64'h0000_0000_0000_9000;
    @(negedge clk); regAddrWe = 1'b0; regStartWe = 1'b1;
    @(negedge clk); regStartWe = 1'b0;
    #1;
    chk("R10 busy launch ignored", {62'd0, txValid, busy}, 64'd1);
    sendCpl(3'b010, 3'b000, expTag, 32'h4444_4444);
    chk("R10 in-flight request completes", {32'd0, rdData}, 64'h0000_0000_4444_4444);
    expTag++;
    timeoutCycles = 16'd400;

    // data completion with non-zero status
    a = 64'h0000_0000_0000_4008;
    issue(a); checkHdr(a, expTag);
    sendCpl(3'b010, 3'b100, expTag, 32'h5555_5555);
    chk("R7 bad status with data", {58'd0, errStatus, done, errCpl, errTimeout}, {58'd0, 3'b100, 3'b010});
    chk("R7 read data untouched", {32'd0, rdData}, 64'h0000_0000_4444_4444);
    expTag++;

    // random mix, long enough to wrap the tag (R5)
    for (int it = 0; it < 260; it++) begin
      a = randAddr();
      issue(a); checkHdr(a, expTag);
      r = $urandom % 3;
      d = $urandom;
      if (r == 1) begin
        s = (($urandom % 2) != 0) ? 3'b001 : 3'b100;
        sendCpl(3'b000, s, expTag, 32'd0);
        chk("R7 random failure", {58'd0, errStatus, done, errCpl, errTimeout}, {58'd0, s, 3'b010});
      end else begin
        if (r == 2) sendCpl(3'b010, 3'b000, expTag + 8'd1, 32'hFFFF_0000);
        sendCpl(3'b010, 3'b000, expTag, d);
        chk("R6 random success", {31'd0, rdData, done}, {31'd0, d, 1'b1});
      end
      expTag++;
    end
    chk("R5 tag wrapped", {56'd0, expTag}, {56'd0, 8'd10});

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule